// File: doc/BRIEF.md
# Quad I/O Flash Read Controller

This block is the host side of a serial NOR flash read path that uses the quad-I/O read command. A client hands it a 24-bit start address and a byte count. The block then drives chip select and a serial clock at half the system clock rate, and runs the four data lines through separate output, output-enable and input pins. It returns the bytes it reads on a valid/ready stream. It sends the address only once per request, because the flash advances its own address after every byte and wraps from the top of the array back to zero.

Each request picks one of two sequences. In the plain sequence, the opcode goes out on line 0, the address follows on all four lines, and six dummy clocks come before the data. In the enhanced sequence, a mode byte follows the address, and after it come four dummy clocks. A mode byte whose high nibble is the bitwise complement of its low nibble leaves the flash in continuous mode. The next request then starts directly with the address. Any other mode byte, or a later plain request, brings the flash back to opcode-first sequencing. For a plain request made while the flash is in continuous mode, the block sends an all-ones mode byte.

Back-pressure: the output byte stays on `dout_data`, with `dout_valid` high, until `dout_ready` is seen high. While a completed byte is waiting in the data phase, the serial clock is held low. No byte is ever dropped. The transfer simply slows to the consumer's pace.

Top module: `quad_flash_reader`

## Requirements
- R1: Out of reset and between transactions, `fl_cs_n` is 1, `fl_sck` is 0, `fl_io_oe` is 0 and `dout_valid` is 0. `fl_sck` is never high for two clock cycles in a row.
- R2: When the flash is not in continuous mode, a transaction starts with 8 SCK clocks that carry the opcode (default 0xEB), MSB first, on line 0 only. During these clocks `fl_io_oe` is 4'b0001.
- R3: The 24-bit start address goes out once per request, over 6 SCK clocks, with `fl_io_oe` equal to 4'b1111. The most significant nibble goes first, and line 3 carries the nibble's MSB.
- R4: A plain request with no mode byte places 6 dummy clocks after the address. A request for N bytes made outside continuous mode produces exactly 20 + 2N SCK rising edges.
- R5: `fl_io_oe` is 0 on every SCK rising edge of the dummy and data phases. It drops at the falling edge that ends the address or mode phase.
- R6: Each byte is formed from two nibbles sampled on SCK rising edges, the first sampled nibble being bits 7:4. Exactly (`req_cnt_m1` + 1) bytes are returned, in address order.
- R7: While `dout_valid` is 1 and `dout_ready` is 0, `dout_valid` stays 1 and `dout_data` stays the same on the next cycle. The byte sequence is the same under any ready pattern.
- R8: While `dev_busy` is 1, `req_ready` is 0 and no transaction starts.
- R9: A request with `req_enh`=1 sends `req_mode` over 2 SCK clocks after the address, high nibble first, followed by 4 dummy clocks.
- R10: After a mode byte with bits 7:4 equal to the complement of bits 3:0, the next transaction has no opcode phase and produces 12 + 2N SCK rising edges.
- R11: A plain request made in continuous mode sends mode byte 0xFF. After that, or after any mode byte that is not a continuation code, the next transaction begins with the opcode again.
- R12: `fl_cs_n` rises right after the last data nibble has been sampled, and it stays high for at least GAP_CYC (default 4) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 24 | Start byte address |
| req_cnt_m1 | input | 16 | Byte count minus one |
| req_enh | input | 1 | Use the enhanced sequence with a mode byte |
| req_mode | input | 8 | Mode byte sent when req_enh is 1 |
| dev_busy | input | 1 | Flash is in a program, erase or status-write cycle; blocks requests |
| dout_valid | output | 1 | Read byte available |
| dout_ready | input | 1 | Consumer takes the byte |
| dout_data | output | 8 | Read byte |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sck | output | 1 | Flash serial clock |
| fl_io_out | output | 4 | Values driven onto data lines 3..0 |
| fl_io_oe | output | 4 | Per-line output enable |
| fl_io_in | input | 4 | Values read from data lines 3..0 |

## Verification
The assertions assume that `dout_ready` and the request fields are synchronous to `clk` and settle away from its rising edge. They also assume that `dev_busy` changes only while no request is in flight. The bench drives all inputs half a cycle after each edge. It raises `dev_busy` only while the block is idle, and it holds every request field steady until the handshake. Its flash model launches data nibbles only on SCK falling edges while chip select is low, which is the condition the stream-stability property relies on.

// File: rtl/qfr_pkg.sv
package qfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_MODE,
    ST_DUMMY,
    ST_DATA,
    ST_GAP
  } qfr_state_e;

  // a mode byte keeps continuous sequencing when its halves are complements
  function automatic logic mode_keeps(input logic [7:0] m);
    return m[7:4] == ~m[3:0];
  endfunction

endpackage

// File: rtl/qfr_sck_gen.sv
// Serial clock divider: one rise per enabled low cycle, always falls next cycle.
module qfr_sck_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic sck,
  output logic rise_now,
  output logic fall_now
);

  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sck_q <= 1'b0;
    else if (sck_q)            sck_q <= 1'b0;
    else if (run && !hold)     sck_q <= 1'b1;
  end

  assign rise_now = !sck_q && run && !hold;
  assign fall_now = sck_q;
  assign sck      = sck_q;

endmodule

// File: rtl/qfr_line_drv.sv
// Selects what the host drives on the four lines for the current phase slot.
module qfr_line_drv
  import qfr_pkg::*;
#(
  parameter int          ADDR_W = 24,
  parameter logic [7:0]  OPCODE = 8'hEB,
  parameter int          CW     = 4
)(
  input  qfr_state_e        state,
  input  logic [CW-1:0]     slot,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        mode,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe
);

  logic [7:0]        opc_sh;
  logic [ADDR_W-1:0] addr_sh;
  logic [7:0]        mode_sh;

  always_comb begin
    opc_sh  = OPCODE << slot;
    addr_sh = addr << {slot, 2'b00};
    mode_sh = mode << {slot, 2'b00};
    io_out  = 4'h0;
    io_oe   = 4'h0;
    case (state)
      ST_CMD: begin
        io_out = {3'b000, opc_sh[7]};
        io_oe  = 4'b0001;
      end
      ST_ADDR: begin
        io_out = addr_sh[ADDR_W-1 -: 4];
        io_oe  = 4'b1111;
      end
      ST_MODE: begin
        io_out = mode_sh[7:4];
        io_oe  = 4'b1111;
      end
      default: begin
        io_out = 4'h0;
        io_oe  = 4'h0;
      end
    endcase
  end

endmodule

// File: rtl/qfr_nib_pack.sv
// Joins sampled nibbles into bytes (first nibble high) and holds one byte for the stream.
module qfr_nib_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nib_vld,
  input  logic [3:0] nib,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);

  logic       half_q;
  logic [3:0] hi_q;
  logic       valid_q;
  logic [7:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      hi_q    <= 4'h0;
      valid_q <= 1'b0;
      data_q  <= 8'h00;
    end else begin
      if (valid_q && out_ready) valid_q <= 1'b0;
      if (nib_vld) begin
        if (!half_q) begin
          hi_q   <= nib;
          half_q <= 1'b1;
        end else begin
          data_q  <= {hi_q, nib};
          valid_q <= 1'b1;
          half_q  <= 1'b0;
        end
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

endmodule

// File: rtl/quad_flash_reader.sv
module quad_flash_reader
  import qfr_pkg::*;
#(
  parameter int         ADDR_W      = 24,
  parameter int         CNT_W       = 16,
  parameter logic [7:0] OPCODE      = 8'hEB,
  parameter logic [7:0] EXIT_MODE   = 8'hFF,
  parameter int         DUMMY_PLAIN = 6,
  parameter int         DUMMY_ENH   = 4,
  parameter int         GAP_CYC     = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_cnt_m1,
  input  logic              req_enh,
  input  logic [7:0]        req_mode,
  input  logic              dev_busy,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [7:0]        dout_data,
  output logic              fl_cs_n,
  output logic              fl_sck,
  output logic [3:0]        fl_io_out,
  output logic [3:0]        fl_io_oe,
  input  logic [3:0]        fl_io_in
);

  localparam int CW   = 4;
  localparam int ANIB = ADDR_W / 4;
  localparam int NLW  = CNT_W + 1;
  localparam int GW   = $clog2(GAP_CYC + 1);

  qfr_state_e        state_q;
  logic [CW-1:0]     slot_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        mode_q;
  logic              use_mode_q;
  logic              cont_q;
  logic [NLW-1:0]    nleft_q;
  logic [GW-1:0]     gap_q;

  logic              run, hold, sck_rise, sck_fall, accept;
  logic [CW-1:0]     dummy_last;

  assign req_ready  = (state_q == ST_IDLE) && !dev_busy;
  assign accept     = req_valid && req_ready;
  assign run        = (state_q != ST_IDLE) && (state_q != ST_GAP);
  assign hold       = (state_q == ST_DATA) && dout_valid && !dout_ready;
  assign dummy_last = use_mode_q ? CW'(DUMMY_ENH - 1) : CW'(DUMMY_PLAIN - 1);
  assign fl_cs_n    = (state_q == ST_IDLE) || (state_q == ST_GAP);

  // phase sequencing advances on the clock edge where SCK falls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      slot_q     <= '0;
      addr_q     <= '0;
      mode_q     <= 8'h00;
      use_mode_q <= 1'b0;
      cont_q     <= 1'b0;
      nleft_q    <= '0;
      gap_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q     <= req_addr;
            mode_q     <= req_enh ? req_mode : EXIT_MODE;
            use_mode_q <= req_enh || cont_q;
            nleft_q    <= {req_cnt_m1, 1'b1};
            slot_q     <= '0;
            state_q    <= cont_q ? ST_ADDR : ST_CMD;
          end
        end
        ST_CMD: if (sck_fall) begin
          if (slot_q == CW'(7)) begin
            slot_q  <= '0;
            state_q <= ST_ADDR;
          end else slot_q <= slot_q + 1'b1;
        end
        ST_ADDR: if (sck_fall) begin
          if (slot_q == CW'(ANIB - 1)) begin
            slot_q  <= '0;
            state_q <= use_mode_q ? ST_MODE : ST_DUMMY;
          end else slot_q <= slot_q + 1'b1;
        end
        ST_MODE: if (sck_fall) begin
          if (slot_q == CW'(1)) begin
            slot_q  <= '0;
            cont_q  <= mode_keeps(mode_q);
            state_q <= ST_DUMMY;
          end else slot_q <= slot_q + 1'b1;
        end
        ST_DUMMY: if (sck_fall) begin
          if (slot_q == dummy_last) begin
            slot_q  <= '0;
            state_q <= ST_DATA;
          end else slot_q <= slot_q + 1'b1;
        end
        ST_DATA: if (sck_fall) begin
          if (nleft_q == '0) begin
            gap_q   <= '0;
            state_q <= ST_GAP;
          end else nleft_q <= nleft_q - 1'b1;
        end
        ST_GAP: begin
          if (gap_q == GW'(GAP_CYC - 1)) state_q <= ST_IDLE;
          else                           gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  qfr_sck_gen u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .hold     (hold),
    .sck      (fl_sck),
    .rise_now (sck_rise),
    .fall_now (sck_fall)
  );

  qfr_line_drv #(
    .ADDR_W (ADDR_W),
    .OPCODE (OPCODE),
    .CW     (CW)
  ) u_drv (
    .state  (state_q),
    .slot   (slot_q),
    .addr   (addr_q),
    .mode   (mode_q),
    .io_out (fl_io_out),
    .io_oe  (fl_io_oe)
  );

  qfr_nib_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .nib_vld   (sck_rise && (state_q == ST_DATA)),
    .nib       (fl_io_in),
    .out_valid (dout_valid),
    .out_ready (dout_ready),
    .out_data  (dout_data)
  );

endmodule

// File: rtl/qfr_chk.sv
module qfr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       dev_busy,
  input logic       dout_valid,
  input logic       dout_ready,
  input logic [7:0] dout_data,
  input logic       fl_cs_n,
  input logic       fl_sck,
  input logic [3:0] fl_io_oe
);

  // R1: deselected means quiet clock and released lines
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> (fl_io_oe == 4'h0 && !fl_sck));

  // R1: SCK high lasts one system cycle
  a_r1_sck_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fl_sck |=> !fl_sck);

  // R3: only single-line or full-width drive patterns appear
  a_r3_oe_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_io_oe != 4'h0) |-> (fl_io_oe == 4'h1 || fl_io_oe == 4'hF));

  // R7: a stalled byte stays put
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  // R8: busy flash blocks acceptance
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dev_busy |-> !req_ready);

  // R12: deselect lasts more than one cycle
  a_r12_deselect_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_cs_n) |=> fl_cs_n);

endmodule

bind quad_flash_reader qfr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .dev_busy   (dev_busy),
  .dout_valid (dout_valid),
  .dout_ready (dout_ready),
  .dout_data  (dout_data),
  .fl_cs_n    (fl_cs_n),
  .fl_sck     (fl_sck),
  .fl_io_oe   (fl_io_oe)
);

// File: tb/tb_quad_flash_reader.sv
module tb_quad_flash_reader;

  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_cnt_m1 = '0;
  logic        req_enh = 1'b0;
  logic [7:0]  req_mode = '0;
  logic        dev_busy = 1'b0;
  logic        dout_valid;
  logic        dout_ready = 1'b0;
  logic [7:0]  dout_data;
  logic        fl_cs_n, fl_sck;
  logic [3:0]  fl_io_out, fl_io_oe;
  logic [3:0]  fl_io_in = 4'h0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  quad_flash_reader dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cnt_m1(req_cnt_m1),
    .req_enh(req_enh), .req_mode(req_mode), .dev_busy(dev_busy),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .fl_cs_n(fl_cs_n), .fl_sck(fl_sck),
    .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in)
  );

  function automatic logic [7:0] dev_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic bit keeps(input logic [7:0] m);
    return m[7:4] == ~m[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  int          r = 0;
  int          k = 0;
  int          base = 8;
  int          perr = 0;
  bit          st_cont = 0;
  bit          dev_cont = 0;
  bit          exp_mp = 0;
  logic [7:0]  m_opc = '0;
  logic [23:0] m_addr = '0;
  logic [7:0]  m_mode = '0;

  always @(negedge fl_cs_n) begin
    r = 0; k = 0; perr = 0;
    st_cont = dev_cont;
    base = dev_cont ? 0 : 8;
    m_opc = '0; m_addr = '0; m_mode = '0;
  end

  always @(posedge fl_sck) begin
    if (r < base) begin
      m_opc = {m_opc[6:0], fl_io_out[0]};
      if (fl_io_oe != 4'h1) perr++;
    end else if (r < base + 6) begin
      m_addr = {m_addr[19:0], fl_io_out};
      if (fl_io_oe != 4'hF) perr++;
    end else if (exp_mp && r < base + 8) begin
      m_mode = {m_mode[3:0], fl_io_out};
      if (fl_io_oe != 4'hF) perr++;
    end else if (fl_io_oe != 4'h0) perr++;
    r++;
  end

  always @(negedge fl_sck) begin
    if (!fl_cs_n && r >= base + 12) begin
      logic [7:0] b;
      b = dev_byte(m_addr + 24'(k / 2));
      fl_io_in <= (k % 2 == 0) ? b[7:4] : b[3:0];
      k++;
    end
  end

  always @(posedge fl_cs_n) begin
    if (r > 0) dev_cont = exp_mp && keeps(m_mode);
  end

  // ---------------- deselect length monitor ----------------
  int hi_run = 0;
  int min_gap = 1000;
  bit first_sel = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_cs_n) hi_run++;
      else begin
        if (hi_run > 0 && first_sel && hi_run < min_gap) min_gap = hi_run;
        if (hi_run > 0) first_sel = 1;
        hi_run = 0;
      end
    end
  end

  // ---------------- scenario tasks ----------------
  bit exp_cont = 0;

  task automatic do_read(input logic [23:0] a, input int n, input bit enh,
                         input logic [7:0] md, input int pat);
    logic [7:0]  sent, got_b, exp_b;
    bit          mp, data_ok;
    int          b0, got, guard;
    logic [7:0]  bad_a, bad_e;
    string       rt;
    sent = enh ? md : 8'hFF;
    mp = enh || exp_cont;
    b0 = exp_cont ? 0 : 8;
    exp_mp = mp;
    got = 0; guard = 0; data_ok = 1; bad_a = 0; bad_e = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_cnt_m1 = 16'(n - 1);
    req_enh = enh; req_mode = md;
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 0;
    while (got < n && guard < 5000) begin
      dout_ready = (pat == 0) ? 1'b1 : ((guard % 3) == 0);
      #1;
      if (dout_valid && dout_ready) begin
        got_b = dout_data;
        exp_b = dev_byte(a + 24'(got));
        if (got_b !== exp_b && data_ok) begin
          data_ok = 0; bad_a = got_b; bad_e = exp_b;
        end
        got++;
      end
      @(negedge clk); guard++;
    end
    dout_ready = 0;
    while (!fl_cs_n && guard < 6000) begin @(negedge clk); guard++; end
    chk(got == n, "R6", "byte count", got, n);
    if (pat == 0) chk(data_ok, "R6", "byte value", bad_a, bad_e);
    else          chk(data_ok, "R7", "byte value under stall", bad_a, bad_e);
    if (!exp_cont) chk(m_opc == 8'hEB, "R2", "opcode", m_opc, 8'hEB);
    chk(m_addr == a, "R3", "address", m_addr, a);
    rt = exp_cont ? "R10" : (mp ? "R9" : "R4");
    chk(r == b0 + 12 + 2 * n, rt, "SCK rising edges", r, b0 + 12 + 2 * n);
    if (mp) begin
      if (enh) chk(m_mode == sent, "R9", "mode byte", m_mode, sent);
      else     chk(m_mode == sent, "R11", "exit mode byte", m_mode, sent);
    end
    chk(perr == 0, "R5", "line drive per phase", perr, 0);
    exp_cont = mp && keeps(sent);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(fl_cs_n == 1'b1 && fl_sck == 1'b0 && fl_io_oe == 4'h0 && dout_valid == 1'b0,
        "R1", "idle outputs", {fl_cs_n, fl_sck, fl_io_oe, dout_valid}, 7'b1000000);
    chk(req_ready == 1'b1, "R1", "ready when idle", req_ready, 1);
  endtask

  task automatic t_busy();
    bit bad;
    bad = 0;
    @(negedge clk);
    dev_busy = 1; req_valid = 1; req_addr = 24'h000777; req_cnt_m1 = 0;
    req_enh = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (req_ready || !fl_cs_n) bad = 1;
    end
    chk(!bad, "R8", "busy blocks start", bad, 0);
    req_valid = 0;
    @(negedge clk);
    dev_busy = 0;
    @(negedge clk);
    chk(fl_cs_n == 1'b1, "R8", "no start after withdrawn request", fl_cs_n, 1);
  endtask

  task automatic t_normal();
    do_read(24'h001234, 4, 0, 8'h00, 0);
    do_read(24'hFFFFFE, 4, 0, 8'h00, 0);
  endtask

  task automatic t_backpressure();
    do_read(24'h000100, 6, 0, 8'h00, 1);
  endtask

  task automatic t_enhance();
    do_read(24'h00AB00, 2, 1, 8'h00, 0);
    do_read(24'h000010, 2, 0, 8'h00, 0);
    do_read(24'h020000, 3, 1, 8'hA5, 0);
    do_read(24'h123456, 3, 1, 8'hA5, 1);
    do_read(24'h000040, 2, 0, 8'h00, 0);
    do_read(24'h000050, 2, 0, 8'h00, 0);
  endtask

  task automatic t_gap();
    chk(min_gap >= GAP, "R12", "shortest deselect", min_gap, GAP);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_normal();
    t_busy();
    t_backpressure();
    t_enhance();
    t_gap();
    finish_run();
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete actual=1 expected=0");
    finish_run();
  end

endmodule